// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is an 8-bit up-counter that software programs through a narrow 4-bit register port. Software sets the reload value in two nibble writes. The lower nibble goes into a staging register. A later write of the upper nibble joins the two halves and commits the full value. The commit updates the reload register and also the running count.

The timer advances once for each cycle in which an external count-enable tick is present and its run bit is set. When the count passes 0xFF it does not wrap to zero. It takes the stored reload value instead. On that overflow it emits a one-cycle pulse and sets a sticky interrupt request flag, which software clears with a dedicated strobe. The reload register keeps its contents, so the timer produces a steady period with no software involvement.

The register port is plain control/status: writes complete in the cycle the strobe is sampled and reads are combinational. No stream handshake is used, and back-pressure does not apply.

Top module: `autoreload_timer`

## Requirements
- R1: After reset the count, the staged nibble, the reload value, the run bit, the request flag and the overflow pulse are all zero.
- R2: A write to address 0 (low nibble) only updates the staging register. The count keeps its value, and the value loaded at the next overflow is unchanged.
- R3: A write to address 1 (high nibble) commits {written nibble, staged low nibble} into both the reload register and the count, visible in the next cycle. This commit takes precedence over a tick in the same cycle.
- R4: The count increases by one on each clock edge where the tick input and the run bit (address 2, bit 0) are both 1. Otherwise it holds.
- R5: A counting edge with count 0xFF loads the reload value instead of zero and drives the overflow pulse high for exactly the following cycle.
- R6: The reload register keeps its value across overflows, so every later overflow loads the same value, including back-to-back overflows with reload 0xFF.
- R7: Overflow sets the request flag, which stays set until the clear input is high at a clock edge. When overflow and clear coincide, the flag ends set.
- R8: Reads return count[3:0] at address 0 and count[7:4] at address 1. Address 2 returns {2'b00, flag, run}. Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| tick_i | input | 1 | Prescaled count enable |
| irq_clr_i | input | 1 | Request flag clear strobe |
| ovf_pulse_o | output | 1 | One-cycle overflow pulse |
| irq_flag_o | output | 1 | Sticky interrupt request flag |

## Verification
The bench stages a new low nibble without committing it, then lets the timer overflow. A design that forwards the staged nibble early reloads 0xFA where 0xF5 is expected. It writes the high nibble in the same cycle as a tick, which exposes a counter that increments the fresh value. It asserts clear in the same cycle as an overflow, which catches a flag that drops a request. It sets reload 0xFF so that every tick overflows, which reveals a pulse that fails to repeat or a counter that wraps to zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control register bit positions (address NUM_NIB)
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FLAG_BIT = 1;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_STAGE  = 2'd1,
    ACC_COMMIT = 2'd2,
    ACC_CTRL   = 2'd3
  } reg_access_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 2,
  parameter int ADDR_W  = 2,
  localparam int CNT_W  = NIB_W * NUM_NIB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wdata,
  output logic              run_o,
  output logic              commit_o,
  output logic [CNT_W-1:0]  commit_val_o,
  output logic [CNT_W-1:0]  reload_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(NUM_NIB - 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_NIB);

  reg_access_e acc;
  logic [NUM_NIB-2:0][NIB_W-1:0] stage_q;
  logic [CNT_W-1:0] reload_q;
  logic run_q;

  always_comb begin
    acc = ACC_NONE;
    if (we) begin
      if (addr == TOP_ADDR)      acc = ACC_COMMIT;
      else if (addr == CTRL_ADDR) acc = ACC_CTRL;
      else if (addr < TOP_ADDR)  acc = ACC_STAGE;
    end
  end

  // Staging registers for every nibble below the top one
  for (genvar g = 0; g < NUM_NIB - 1; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[g] <= '0;
      else if (acc == ACC_STAGE && addr == ADDR_W'(g))
        stage_q[g] <= wdata;
    end
  end

  assign commit_o     = (acc == ACC_COMMIT);
  assign commit_val_o = {wdata, stage_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '0;
    else if (commit_o) reload_q <= commit_val_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (acc == ACC_CTRL) run_q <= wdata[CTRL_RUN_BIT];
  end

  assign run_o    = run_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic step;

  assign step      = tick_i && run_i && !commit_i;
  assign ovf_evt_o = step && (count_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (commit_i)  count_q <= commit_val_i;
    else if (ovf_evt_o) count_q <= reload_i;
    else if (step)      count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= ovf_evt_i;
      if (ovf_evt_i)  flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer
  import tmr_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 2,
  localparam int CNT_W  = NIB_W * NUM_NIB,
  localparam int ADDR_W = $clog2(NUM_NIB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NIB_W-1:0]  reg_wdata,
  output logic [NIB_W-1:0]  reg_rdata,
  input  logic              tick_i,
  input  logic              irq_clr_i,
  output logic              ovf_pulse_o,
  output logic              irq_flag_o
);
  logic             run_w, commit_w, ovf_evt_w;
  logic [CNT_W-1:0] commit_val_w, reload_w, count_w;
  logic [NUM_NIB-1:0][NIB_W-1:0] count_nib;

  tmr_regs #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .run_o(run_w), .commit_o(commit_w), .commit_val_o(commit_val_w),
    .reload_o(reload_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_w),
    .commit_i(commit_w), .commit_val_i(commit_val_w), .reload_i(reload_w),
    .count_o(count_w), .ovf_evt_o(ovf_evt_w)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ovf_evt_i(ovf_evt_w), .clr_i(irq_clr_i),
    .flag_o(irq_flag_o), .pulse_o(ovf_pulse_o)
  );

  assign count_nib = count_w;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_NIB; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = count_nib[i];
    if (reg_addr == ADDR_W'(NUM_NIB)) begin
      reg_rdata[CTRL_RUN_BIT]  = run_w;
      reg_rdata[CTRL_FLAG_BIT] = irq_flag_o;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             commit,
  input logic             stage_wr,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             ovf_pulse,
  input logic             flag
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run) && !commit) |=> $stable(count));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !commit && count != CMAX) |=> count == $past(count) + CNT_W'(1));

  p_stage_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_wr && !run) |=> $stable(count) && $stable(reload));

  p_reload_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !commit && count == CMAX) |=> ovf_pulse && count == $past(reload));

  p_reload_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(reload));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> flag);
endmodule

bind autoreload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(run_w), .commit(commit_w),
  .stage_wr(reg_we && reg_addr == '0), .clr(irq_clr_i), .count(count_w),
  .reload(reload_w), .ovf_pulse(ovf_pulse_o), .flag(irq_flag_o)
);

// File: tb/autoreload_timer_bench.sv
`timescale 1ns/1ps
module autoreload_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic tick_i = 1'b0;
  logic irq_clr_i = 1'b0;
  logic ovf_pulse_o, irq_flag_o;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  autoreload_timer u_autoreload_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
    .irq_clr_i(irq_clr_i), .ovf_pulse_o(ovf_pulse_o), .irq_flag_o(irq_flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_count(output logic [7:0] c);
    logic [3:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] c; logic [3:0] s;
    rd_count(c); chk("R1 count", c, 8'h00);
    rd(2'd2, s);  chk("R1 ctrl", s, 4'h0);
    chk("R1 ovf", ovf_pulse_o, 0);
    chk("R1 flag", irq_flag_o, 0);
  endtask

  task automatic t_commit;
    logic [7:0] c;
    wr(2'd0, 4'h5);
    rd_count(c); chk("R2 low write leaves count", c, 8'h00);
    wr(2'd1, 4'hF);
    rd_count(c); chk("R3 commit to count", c, 8'hF5);
  endtask

  task automatic t_count;
    logic [7:0] c; logic [3:0] s;
    wr(2'd2, 4'h1);
    rd(2'd2, s); chk("R8 ctrl run readback", s, 4'h1);
    ticks(3);
    rd_count(c); chk("R4 three ticks", c, 8'hF8);
    wr(2'd2, 4'h0);
    ticks(2);
    rd_count(c); chk("R4 hold when stopped", c, 8'hF8);
  endtask

  task automatic t_overflow;
    logic [7:0] c; logic [3:0] s;
    wr(2'd2, 4'h1);
    ticks(7);
    rd_count(c); chk("R4 reach max", c, 8'hFF);
    chk("R5 no early pulse", ovf_pulse_o, 0);
    ticks(1);
    chk("R5 pulse", ovf_pulse_o, 1);
    rd_count(c); chk("R5 reload on wrap", c, 8'hF5);
    @(negedge clk);
    chk("R5 pulse one cycle", ovf_pulse_o, 0);
    rd(2'd2, s); chk("R7 flag and run readback", s, 4'h3);
    repeat (3) @(negedge clk);
    chk("R7 flag sticky", irq_flag_o, 1);
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    chk("R7 flag cleared", irq_flag_o, 0);
  endtask

  task automatic t_staging;
    logic [7:0] c;
    wr(2'd0, 4'hA);
    rd_count(c); chk("R2 staging keeps count", c, 8'hF5);
    ticks(10);
    rd_count(c); chk("R4 back at max", c, 8'hFF);
    ticks(1);
    rd_count(c); chk("R2 R6 old reload kept", c, 8'hF5);
    chk("R6 second pulse", ovf_pulse_o, 1);
    wr(2'd1, 4'hE);
    rd_count(c); chk("R3 staged nibble joins", c, 8'hEA);
  endtask

  task automatic t_collide;
    logic [7:0] c;
    wr(2'd0, 4'hF);
    wr(2'd1, 4'hF);
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    chk("R7 cleared before race", irq_flag_o, 0);
    tick_i = 1'b1; irq_clr_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; irq_clr_i = 1'b0;
    chk("R7 set beats clear", irq_flag_o, 1);
    chk("R5 pulse on race", ovf_pulse_o, 1);
    ticks(1);
    chk("R6 back-to-back pulse", ovf_pulse_o, 1);
    rd_count(c); chk("R6 reload FF", c, 8'hFF);
  endtask

  task automatic t_priority;
    logic [7:0] c;
    wr(2'd0, 4'h3);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 4'h4; tick_i = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick_i = 1'b0;
    rd_count(c); chk("R3 commit beats tick", c, 8'h43);
  endtask

  task automatic t_unused;
    logic [7:0] c; logic [3:0] s;
    wr(2'd3, 4'hF);
    rd(2'd3, s); chk("R8 addr3 reads zero", s, 4'h0);
    rd(2'd2, s); chk("R8 addr3 write ignored ctrl", s, 4'h3);
    rd_count(c); chk("R8 addr3 write ignored count", c, 8'h43);
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_count();
    t_overflow();
    t_staging();
    t_collide();
    t_priority();
    t_unused();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule